// File: doc/BRIEF.md
# Floating-Point to Wrapping Integer Converter

This block takes one binary floating-point operand (a sign bit, a biased exponent field and a fraction field) and turns it into a two's-complement integer of fixed width. It applies a rounding mode that the caller selects. It does not saturate. When the value is too large for the integer, the block returns the low bits of the exact integer, which is the value modulo 2^INT_W. The integer-overflow and inexact flags are raised alongside that result. This lets software use the same conversion to get an unsigned result. An infinity or NaN operand gives zero with the invalid flag. Denormal operands are either flushed to zero, which raises no flag, or treated as a tiny nonzero value that rounds according to the mode.

Each operand is accepted through a valid/ready pair. The result and its three flags come out together on a second valid/ready pair. The block holds one operation at a time. While a result waits to be taken, no new operand is accepted. A chop input forces rounding toward zero whatever the mode input says. With the default parameters the operand is an IEEE double and the result is a 64-bit integer.

Top module: `fp2int_wrap_conv`

## Requirements
- R1: An operand whose exponent field is all ones (infinity or NaN) gives result 0 with only the invalid flag set.
- R2: An operand with a zero exponent and a zero fraction gives 0 with no flags. An operand with a zero exponent and a nonzero fraction also gives 0 with no flags when the flush input is high.
- R3: When the flush input is low, a zero exponent with a nonzero fraction counts as a value strictly between 0 and one half in magnitude. It sets inexact. It rounds to 1 under round-up when positive and to -1 (all ones) under round-down when negative. Every other case gives 0.
- R4: Let shift be the exponent minus the bias minus MAN_W. The magnitude is the fraction with its hidden one restored. When shift is 0 or more, the result is the magnitude shifted left by shift, keeping the low INT_W bits. The result is 0 when shift is INT_W or more. There is no rounding.
- R5: When shift is at least INT_W-1-MAN_W, both integer-overflow and inexact are set. One exception applies: the exact most negative integer (sign 1, exponent bias+INT_W-1, fraction 0; 0xC3E0000000000000 by default) sets no flags.
- R6: When shift is negative, the integer part is the magnitude with its fractional bits dropped. Inexact is set exactly when any dropped bit is nonzero.
- R7: The mode input selects rounding on the magnitude: 0 is nearest with ties to even, 1 is toward zero, 2 is toward plus infinity (adds 1 to positive inexact values) and 3 is toward minus infinity (adds 1 to the magnitude of negative inexact values).
- R8: A set sign bit gives the two's-complement negation of the rounded magnitude.
- R9: The chop input high makes the block round toward zero regardless of the mode input.
- R10: The input ready signal is high only when no operation is in flight. The output valid signal rises on the second clock edge after acceptance. It then holds, with result and flags stable, until the output ready signal is seen high at a clock edge.
- R11: After reset the input ready signal is high and the output valid signal is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Operand offered |
| inReady | output | 1 | Block can accept an operand |
| inOperand | input | 1+EXP_W+MAN_W | Floating-point operand: sign, exponent, fraction |
| inRoundMode | input | 2 | Rounding mode: 0 nearest-even, 1 toward zero, 2 up, 3 down |
| inChop | input | 1 | Force toward-zero rounding |
| inFlushDenorm | input | 1 | Treat denormal operands as zero |
| outValid | output | 1 | Result and flags valid |
| outReady | input | 1 | Consumer takes the result |
| outResult | output | INT_W | Two's-complement integer result |
| outInvalid | output | 1 | Operand was infinity or NaN |
| outIntOverflow | output | 1 | Integer did not fit; result wrapped |
| outInexact | output | 1 | Result differs from the operand value |

## Verification
The bench sweeps every operand, rounding mode, chop and flush combination of a narrow configuration and compares each result and flag against arithmetic on the exact value. A fault in the classifier, the shift count or the rounding increment therefore shows on the very first affected result, an output sample that follows acceptance by two edges. A control state that is wrong, such as a lost or duplicated transition, shows within one cycle as a result that arrives early or late or is dropped under back-pressure. Both the latency check and the hold assertions catch that case.

// File: rtl/fp2int_pkg.sv
package fp2int_pkg;

  typedef enum logic [1:0] {
    RND_NEAR_EVEN = 2'd0,
    RND_TO_ZERO   = 2'd1,
    RND_UP        = 2'd2,
    RND_DOWN      = 2'd3
  } rndMode_e;

  typedef struct packed {
    logic loadOp;
    logic storeRes;
  } ctlStrobe_t;

endpackage

// File: rtl/fp2int_ctrl.sv
module fp2int_ctrl
  import fp2int_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       outReady,
  output logic       inReady,
  output logic       outValid,
  output ctlStrobe_t strobe
);

  typedef enum logic [1:0] {ST_IDLE, ST_CALC, ST_HOLD} state_e;
  state_e stateQ, stateD;

  always_comb begin
    stateD = stateQ;
    case (stateQ)
      ST_IDLE: if (inValid) stateD = ST_CALC;
      ST_CALC: stateD = ST_HOLD;
      ST_HOLD: if (outReady) stateD = ST_IDLE;
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  assign inReady         = (stateQ == ST_IDLE);
  assign outValid        = (stateQ == ST_HOLD);
  assign strobe.loadOp   = (stateQ == ST_IDLE) && inValid;
  assign strobe.storeRes = (stateQ == ST_CALC);

endmodule

// File: rtl/fp2int_datapath.sv
module fp2int_datapath
  import fp2int_pkg::*;
#(
  parameter int EXP_W = 11,
  parameter int MAN_W = 52,
  parameter int INT_W = 64
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  ctlStrobe_t                 strobe,
  input  logic [EXP_W+MAN_W:0]       inOperand,
  input  logic [1:0]                 inRoundMode,
  input  logic                       inChop,
  input  logic                       inFlushDenorm,
  output logic [INT_W-1:0]           outResult,
  output logic                       outInvalid,
  output logic                       outIntOverflow,
  output logic                       outInexact
);

  localparam int TOT_W    = 1 + EXP_W + MAN_W;
  localparam int BIAS     = (1 << (EXP_W - 1)) - 1;
  localparam int SH_W     = EXP_W + 2;
  localparam int OVF_SH   = INT_W - 1 - MAN_W;
  localparam int MNEG_EXP = BIAS + INT_W - 1;
  localparam int PAD_W    = INT_W - MAN_W - 1;
  localparam logic [TOT_W-1:0] MOST_NEG = {1'b1, EXP_W'(MNEG_EXP), {MAN_W{1'b0}}};

  // captured operand and controls
  logic [TOT_W-1:0] opQ;
  rndMode_e         modeQ;
  logic             flushQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opQ    <= '0;
      modeQ  <= RND_NEAR_EVEN;
      flushQ <= 1'b0;
    end else if (strobe.loadOp) begin
      opQ    <= inOperand;
      modeQ  <= inChop ? RND_TO_ZERO : rndMode_e'(inRoundMode);
      flushQ <= inFlushDenorm;
    end
  end

  // field split
  logic             signB;
  logic [EXP_W-1:0] expF;
  logic [MAN_W-1:0] fracF;
  logic             expAllOnes, expZero, fracNz;

  assign signB      = opQ[TOT_W-1];
  assign expF       = opQ[TOT_W-2 -: EXP_W];
  assign fracF      = opQ[MAN_W-1:0];
  assign expAllOnes = &expF;
  assign expZero    = ~|expF;
  assign fracNz     = |fracF;

  // shift amount and both shifter directions
  logic signed [SH_W-1:0] shiftAmt;
  logic [SH_W-1:0]        lshAmt, rshAmt;
  logic [INT_W-1:0]       mant, leftVal, rightInt, rightRem;
  logic [2*INT_W-1:0]     wideShift;

  assign shiftAmt  = $signed({2'b00, expF}) - $signed(SH_W'(BIAS + MAN_W));
  assign lshAmt    = shiftAmt;
  assign rshAmt    = -shiftAmt;
  assign mant      = {{PAD_W{1'b0}}, 1'b1, fracF};
  assign wideShift = {mant, {INT_W{1'b0}}} >> rshAmt;

  always_comb begin
    if (shiftAmt >= $signed(SH_W'(INT_W))) leftVal = '0;
    else                                   leftVal = mant << lshAmt;
    if (rshAmt >= SH_W'(INT_W - 1)) begin
      rightInt = '0;
      rightRem = {{(INT_W-1){1'b0}}, 1'b1};
    end else begin
      rightInt = wideShift[2*INT_W-1:INT_W];
      rightRem = wideShift[INT_W-1:0];
    end
  end

  // classification
  logic [INT_W-1:0] magD, remD;
  logic             invD, ovfD;

  always_comb begin
    magD = '0;
    remD = '0;
    invD = 1'b0;
    ovfD = 1'b0;
    if (expAllOnes) begin
      invD = 1'b1;
    end else if (expZero) begin
      if (fracNz && !flushQ) remD = {{(INT_W-1){1'b0}}, 1'b1};
    end else if (shiftAmt >= 0) begin
      magD = leftVal;
      ovfD = (shiftAmt >= $signed(SH_W'(OVF_SH))) && (opQ != MOST_NEG);
    end else begin
      magD = rightInt;
      remD = rightRem;
    end
  end

  // rounding on magnitude, then sign
  logic             remNz, remHalf, remAbove, incD;
  logic [INT_W-1:0] roundedD, resultD;

  assign remNz    = |remD;
  assign remHalf  = remD[INT_W-1] && ~|remD[INT_W-2:0];
  assign remAbove = remD[INT_W-1] &&  |remD[INT_W-2:0];

  always_comb begin
    case (modeQ)
      RND_NEAR_EVEN: incD = remAbove || (remHalf && magD[0]);
      RND_TO_ZERO:   incD = 1'b0;
      RND_UP:        incD = remNz && !signB;
      RND_DOWN:      incD = remNz && signB;
      default:       incD = 1'b0;
    endcase
    roundedD = magD + INT_W'(incD);
    resultD  = signB ? (~roundedD + 1'b1) : roundedD;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outResult      <= '0;
      outInvalid     <= 1'b0;
      outIntOverflow <= 1'b0;
      outInexact     <= 1'b0;
    end else if (strobe.storeRes) begin
      outResult      <= resultD;
      outInvalid     <= invD;
      outIntOverflow <= ovfD;
      outInexact     <= ovfD || remNz;
    end
  end

endmodule

// File: rtl/fp2int_wrap_conv.sv
module fp2int_wrap_conv
  import fp2int_pkg::*;
#(
  parameter int EXP_W = 11,
  parameter int MAN_W = 52,
  parameter int INT_W = 64
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 inValid,
  output logic                 inReady,
  input  logic [EXP_W+MAN_W:0] inOperand,
  input  logic [1:0]           inRoundMode,
  input  logic                 inChop,
  input  logic                 inFlushDenorm,
  output logic                 outValid,
  input  logic                 outReady,
  output logic [INT_W-1:0]     outResult,
  output logic                 outInvalid,
  output logic                 outIntOverflow,
  output logic                 outInexact
);

  ctlStrobe_t strobe;

  fp2int_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .outReady (outReady),
    .inReady  (inReady),
    .outValid (outValid),
    .strobe   (strobe)
  );

  fp2int_datapath #(
    .EXP_W (EXP_W),
    .MAN_W (MAN_W),
    .INT_W (INT_W)
  ) dp_i (
    .clk            (clk),
    .rstN           (rstN),
    .strobe         (strobe),
    .inOperand      (inOperand),
    .inRoundMode    (inRoundMode),
    .inChop         (inChop),
    .inFlushDenorm  (inFlushDenorm),
    .outResult      (outResult),
    .outInvalid     (outInvalid),
    .outIntOverflow (outIntOverflow),
    .outInexact     (outInexact)
  );

endmodule

// File: rtl/fp2int_wrap_conv_chk.sv
module fp2int_wrap_conv_chk #(
  parameter int EXP_W = 11,
  parameter int MAN_W = 52,
  parameter int INT_W = 64
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 inValid,
  input logic                 inReady,
  input logic [EXP_W+MAN_W:0] inOperand,
  input logic                 outValid,
  input logic                 outReady,
  input logic [INT_W-1:0]     outResult,
  input logic                 outInvalid,
  input logic                 outIntOverflow,
  input logic                 outInexact
);

  localparam int TOT_W = 1 + EXP_W + MAN_W;

  logic seenNanInf;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) seenNanInf <= 1'b0;
    else if (inValid && inReady) seenNanInf <= &inOperand[TOT_W-2 -: EXP_W];
  end

  assert_no_accept_pending_R10: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> !inReady);

  assert_hold_result_R10: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && $stable(outResult) && $stable(outInvalid)
                                 && $stable(outIntOverflow) && $stable(outInexact)));

  assert_accept_not_done_R10: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> !outValid);

  assert_accept_latency_R10: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> ##1 outValid);

  assert_nan_inf_R1: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && seenNanInf) |-> (outInvalid && !outIntOverflow && !outInexact && outResult == '0));

  assert_invalid_only_R1: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outInvalid) |-> seenNanInf);

  assert_overflow_inexact_R5: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outIntOverflow) |-> outInexact);

endmodule

bind fp2int_wrap_conv fp2int_wrap_conv_chk #(
  .EXP_W (EXP_W),
  .MAN_W (MAN_W),
  .INT_W (INT_W)
) chk_i (
  .clk            (clk),
  .rstN           (rstN),
  .inValid        (inValid),
  .inReady        (inReady),
  .inOperand      (inOperand),
  .outValid       (outValid),
  .outReady       (outReady),
  .outResult      (outResult),
  .outInvalid     (outInvalid),
  .outIntOverflow (outIntOverflow),
  .outInexact     (outInexact)
);

// File: tb/fp2int_wrap_conv_tb.sv
module fp2int_wrap_conv_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int EXP_W = 5;
  localparam int MAN_W = 4;
  localparam int INT_W = 8;
  localparam int TOT_W = 1 + EXP_W + MAN_W;
  localparam int BIAS  = (1 << (EXP_W - 1)) - 1;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             inValid = 1'b0;
  logic             inReady;
  logic [TOT_W-1:0] inOperand = '0;
  logic [1:0]       inRoundMode = '0;
  logic             inChop = 1'b0;
  logic             inFlushDenorm = 1'b0;
  logic             outValid;
  logic             outReady = 1'b1;
  logic [INT_W-1:0] outResult;
  logic             outInvalid, outIntOverflow, outInexact;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fp2int_wrap_conv #(.EXP_W(EXP_W), .MAN_W(MAN_W), .INT_W(INT_W)) dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inOperand(inOperand), .inRoundMode(inRoundMode), .inChop(inChop),
    .inFlushDenorm(inFlushDenorm), .outValid(outValid), .outReady(outReady),
    .outResult(outResult), .outInvalid(outInvalid),
    .outIntOverflow(outIntOverflow), .outInexact(outInexact)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  endtask

  // Arithmetic reference: returns {result, invalid, overflow, inexact}
  function automatic logic [INT_W+2:0] refModel(input logic [TOT_W-1:0] op, input int mode,
                                                input bit chop, input bit flush);
    bit     sgn = op[TOT_W-1];
    int     e = int'(op[TOT_W-2 -: EXP_W]);
    longint f = longint'(op[MAN_W-1:0]);
    bit     inv = 0, ovf = 0, inx = 0, remNz = 0, above = 0, half = 0;
    longint q = 0;
    int     m = chop ? 1 : mode;
    logic [INT_W-1:0] res;
    if (e == (1 << EXP_W) - 1) begin
      inv = 1;
    end else if (e == 0) begin
      if (f != 0 && !flush) remNz = 1;   // tiny nonzero, below one half (R3)
    end else begin
      longint mag = f + (longint'(1) << MAN_W);
      int sh = e - BIAS - MAN_W;
      if (sh >= 0) begin
        longint big = mag << sh;
        longint sv = sgn ? -big : big;
        if (sv < -(longint'(1) << (INT_W-1)) || sv > (longint'(1) << (INT_W-1)) - 1) begin
          ovf = 1; inx = 1;
        end
        q = big;
      end else begin
        int r = -sh;
        longint rem;
        q = mag >> r;
        rem = mag - (q << r);
        remNz = (rem != 0);
        above = (rem * 2) > (longint'(1) << r);
        half  = (rem * 2) == (longint'(1) << r);
      end
    end
    if (remNz) inx = 1;
    case (m)
      0: if (above || (half && q[0])) q = q + 1;
      2: if (remNz && !sgn) q = q + 1;
      3: if (remNz && sgn) q = q + 1;
      default: ;
    endcase
    res = INT_W'(sgn ? -q : q);
    return {res, inv, ovf, inx};
  endfunction

  function automatic string reqOf(input logic [TOT_W-1:0] op, input bit chop);
    int e = int'(op[TOT_W-2 -: EXP_W]);
    int sh = e - BIAS - MAN_W;
    if (e == (1 << EXP_W) - 1) return "R1";
    if (e == 0) return (op[MAN_W-1:0] == 0) ? "R2" : "R3";
    if (chop) return "R9";
    if (sh >= INT_W - 1 - MAN_W) return "R5";
    if (sh >= 0) return "R4";
    return op[TOT_W-1] ? "R8" : "R7/R6";
  endfunction

  task automatic runOp(input logic [TOT_W-1:0] op, input int mode, input bit chop, input bit flush);
    logic [INT_W+2:0] exp;
    @(negedge clk);
    inOperand = op; inRoundMode = 2'(mode); inChop = chop; inFlushDenorm = flush;
    inValid = 1'b1; outReady = 1'b1;
    check(inReady == 1'b1, "R10 ready", longint'(inReady), 1);
    @(negedge clk);
    inValid = 1'b0;
    check(outValid == 1'b0, "R10 early", longint'(outValid), 0);
    @(negedge clk);
    check(outValid == 1'b1, "R10 late", longint'(outValid), 1);
    exp = refModel(op, mode, chop, flush);
    check({outResult, outInvalid, outIntOverflow, outInexact} == exp, reqOf(op, chop),
          longint'({outResult, outInvalid, outIntOverflow, outInexact}), longint'(exp));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    logic [INT_W-1:0] held;
    repeat (3) @(negedge clk);
    check(inReady == 1'b1 && outValid == 1'b0, "R11", longint'({inReady, outValid}), 2);
    rstN = 1'b1;
    @(negedge clk);

    // R10 back-pressure: result held while outReady is low
    inOperand = {1'b1, 5'd17, 4'd8}; inRoundMode = 2'd1; inValid = 1'b1; outReady = 1'b0;
    @(negedge clk); inValid = 1'b0;
    @(negedge clk);
    held = outResult;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check(outValid && !inReady && outResult == held, "R10 hold",
            longint'(outResult), longint'(held));
    end
    // -(24/16 * 4) = -6 exactly
    check(outResult == 8'hFA && !outInexact, "R8 hold value", longint'(outResult), 'hFA);
    outReady = 1'b1;
    @(negedge clk);
    check(!outValid && inReady, "R10 release", longint'({outValid, inReady}), 1);

    // directed corners: most negative no overflow, positive twin overflows
    runOp({1'b1, 5'd22, 4'd0}, 0, 1'b0, 1'b0);   // R5 exception
    runOp({1'b0, 5'd22, 4'd0}, 0, 1'b0, 1'b0);   // R5 overflow
    runOp({1'b0, 5'd0, 4'd3}, 2, 1'b0, 1'b0);    // R3 up -> 1
    runOp({1'b1, 5'd0, 4'd3}, 3, 1'b0, 1'b0);    // R3 down -> -1
    runOp({1'b0, 5'd0, 4'd3}, 2, 1'b0, 1'b1);    // R2 flushed

    // exhaustive sweep of the narrow configuration
    for (int op = 0; op < (1 << TOT_W); op++)
      for (int md = 0; md < 4; md++)
        for (int ch = 0; ch < 2; ch++)
          for (int fl = 0; fl < 2; fl++)
            runOp(TOT_W'(op), md, ch[0], fl[0]);

    finish_run();
  end

endmodule